// File: doc/BRIEF.md
# Framed Rate-1/2 Convolutional Encoder

This block turns a serial stream of message bits into a stream of two-bit channel symbols. It uses a rate-1/2 convolutional code with constraint length 3, and the tap sets are 7 and 5 in octal. The message is cut into frames of fixed length. After the last message bit of a frame the block inserts zero-valued tail bits of its own, so every frame ends with the encoder history back at zero.

Message bits arrive on a valid/ready handshake. A start-of-frame flag can travel with any bit. Each accepted bit produces one registered symbol in the next cycle. While the tail is being emitted the block lowers its ready output and produces one tail symbol per cycle. The last symbol of each frame carries an end-of-frame flag. A downstream decoder can therefore start every frame from the zero state.

Top module: `conv_frame_enc`

## Requirements
- R1: While reset is held and after it is released, out_valid and out_eof are 0 and in_ready is 1.
- R2: A bit that is accepted (in_valid and in_ready both high at a clock edge) produces exactly one symbol, and out_valid is high in the following cycle. A cycle with in_ready high and in_valid low produces no symbol.
- R3: For an input bit b whose previous bit is m1 and whose bit before that is m2, the symbol is out_sym[1] = b^m1^m2 (generator 7, sent first) and out_sym[0] = b^m2 (generator 5, sent second).
- R4: The history (m1, m2) is zero for the first bit of every frame, including a frame that follows a full frame.
- R5: After the 15th message bit of a frame is accepted, in_ready is low for exactly 3 cycles. In those cycles the block emits 3 symbols computed with b = 0, one per cycle.
- R6: out_eof is high only on the 18th symbol of a frame, which is the last tail symbol, and in_ready is high again in that same cycle.
- R7: An accepted bit with in_sof high becomes bit 1 of a new frame with zero history, and any partial frame in progress is dropped without a tail.
- R8: A 60-bit message sent as one stream becomes 4 frames and 72 symbols in total, with exactly 4 end-of-frame flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Message bit present |
| in_ready | output | 1 | Block can accept a message bit |
| in_bit | input | 1 | Message bit |
| in_sof | input | 1 | Bit starts a new frame |
| out_valid | output | 1 | Symbol present |
| out_sym | output | 2 | Channel symbol, bit 1 = generator 7, bit 0 = generator 5 |
| out_eof | output | 1 | Last symbol of a frame |

## Verification
A symbol for an accepted bit is due exactly one clock after the accepting edge. The three tail symbols follow on the next three edges, with ready low over the same three cycles. The bench drives inputs on falling edges and captures every valid symbol and flag on the falling edge after the producing rising edge. It then compares that log, entry by entry and in order, with a reference list that it builds from the requirements. The tail-timing check samples in_ready on the three falling edges after the 15th bit and again on the fourth.

// File: rtl/conv_frame_enc.sv
module conv_frame_enc #(
  parameter int MSG_LEN  = 15,
  parameter int TAIL_LEN = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic       in_bit,
  input  logic       in_sof,
  output logic       out_valid,
  output logic [1:0] out_sym,
  output logic       out_eof
);
  localparam int FRAME_LEN = MSG_LEN + TAIL_LEN;
  localparam int CW        = $clog2(FRAME_LEN + 1);

  logic [CW-1:0] pos;
  logic [1:0]    hist;

  wire       in_tail = pos >= CW'(MSG_LEN);
  assign     in_ready = !in_tail;
  wire       take    = in_valid && !in_tail;
  wire       step    = take || in_tail;
  wire       restart = take && in_sof;
  wire [1:0] h       = restart ? 2'b00 : hist;
  wire       b       = take ? in_bit : 1'b0;
  wire       last    = pos == CW'(FRAME_LEN - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos       <= '0;
      hist      <= '0;
      out_valid <= 1'b0;
      out_sym   <= '0;
      out_eof   <= 1'b0;
    end else begin
      out_valid <= step;
      out_eof   <= in_tail && last;
      if (step) begin
        out_sym <= {b ^ h[0] ^ h[1], b ^ h[1]};
        hist    <= last ? 2'b00 : {h[0], b};
        if (last)         pos <= '0;
        else if (restart) pos <= CW'(1);
        else              pos <= pos + CW'(1);
      end
    end
  end
endmodule

// File: rtl/conv_frame_enc_chk.sv
module conv_frame_enc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_eof
);
  a_r2_take_emits: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> !out_valid);
  a_r5_tail_emits: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> out_valid);
  a_r6_eof_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_eof |-> out_valid);
  a_r6_eof_reopens: assert property (@(posedge clk) disable iff (!rst_n)
    out_eof |-> in_ready);
  a_r6_eof_after_tail: assert property (@(posedge clk) disable iff (!rst_n)
    out_eof |-> $past(!in_ready));
endmodule

bind conv_frame_enc conv_frame_enc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_eof(out_eof)
);

// File: tb/sim_conv_frame_enc.sv
`timescale 1ns/1ps
module sim_conv_frame_enc;
  logic clk = 0, rst_n = 0, in_valid = 0, in_bit = 0, in_sof = 0;
  logic in_ready, out_valid, out_eof;
  logic [1:0] out_sym;
  int total = 0, bad = 0;

  conv_frame_enc u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_bit(in_bit), .in_sof(in_sof), .out_valid(out_valid), .out_sym(out_sym), .out_eof(out_eof));

  always #2 clk = ~clk;

  logic [1:0] got_sym [0:255];
  logic       got_eof [0:255];
  int         got_n = 0;
  logic [1:0] exp_sym [0:255];
  logic       exp_eof [0:255];
  int         exp_n = 0;
  logic m1 = 0, m2 = 0;
  int   fpos = 0;

  always @(negedge clk) if (rst_n && out_valid && got_n < 256) begin
    got_sym[got_n] = out_sym; got_eof[got_n] = out_eof; got_n++;
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_push(input logic b, input logic s);
    if (s) begin m1 = 0; m2 = 0; fpos = 0; end
    exp_sym[exp_n] = {b ^ m1 ^ m2, b ^ m2}; exp_eof[exp_n] = 0; exp_n++;
    m2 = m1; m1 = b; fpos++;
    if (fpos == 15) begin
      for (int i = 0; i < 3; i++) begin
        exp_sym[exp_n] = {m1 ^ m2, m2}; exp_eof[exp_n] = (i == 2); exp_n++;
        m2 = m1; m1 = 0;
      end
      fpos = 0;
    end
  endtask

  task automatic put(input logic b, input logic s);
    @(negedge clk);
    while (!in_ready) begin in_valid = 0; @(negedge clk); end
    in_valid = 1; in_bit = b; in_sof = s;
    model_push(b, s);
  endtask

  task automatic idle(input int n);
    @(negedge clk); in_valid = 0; in_sof = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic compare(input string req);
    idle(8);
    chk({req, " symbol count"}, got_n, exp_n);
    for (int i = 0; i < exp_n && i < got_n; i++) begin
      chk({req, " symbol"}, got_sym[i], exp_sym[i]);
      chk("R6 eof flag", got_eof[i], exp_eof[i]);
    end
    got_n = 0; exp_n = 0;
  endtask

  task automatic t_reset;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R1 out_valid in reset", out_valid, 0);
    chk("R1 in_ready in reset", in_ready, 1);
    rst_n = 1;
    @(negedge clk);
    chk("R1 out_valid after reset", out_valid, 0);
    chk("R1 out_eof after reset", out_eof, 0);
    chk("R1 in_ready after reset", in_ready, 1);
    got_n = 0; exp_n = 0; m1 = 0; m2 = 0; fpos = 0;
  endtask

  task automatic t_ones_tail;
    for (int i = 0; i < 15; i++) put(1'b1, i == 0);
    @(negedge clk); in_valid = 0;
    chk("R5 ready low tail 1", in_ready, 0);
    @(negedge clk); chk("R5 ready low tail 2", in_ready, 0);
    @(negedge clk); chk("R5 ready low tail 3", in_ready, 0);
    @(negedge clk); chk("R5 ready back", in_ready, 1);
    compare("R3 R5 ones");
  endtask

  task automatic t_gaps;
    for (int i = 0; i < 15; i++) begin
      put(i[0], 1'b0);
      if (i % 4 == 1) idle(2);
    end
    compare("R2 gapped");
  endtask

  task automatic t_two_frames;
    for (int i = 0; i < 30; i++) put((i % 3) != 0 || i == 14, 1'b0);
    compare("R4 back-to-back");
  endtask

  task automatic t_sof_restart;
    for (int i = 0; i < 6; i++) put(1'b1, 1'b0);
    for (int i = 0; i < 15; i++) put(i < 2, i == 0);
    compare("R7 sof restart");
  endtask

  task automatic t_four_frames;
    logic [7:0] lf = 8'hA5;
    int eofs = 0;
    for (int i = 0; i < 60; i++) begin
      put(lf[0], 1'b0);
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    end
    idle(8);
    for (int i = 0; i < got_n; i++) eofs += got_eof[i];
    chk("R8 eof count", eofs, 4);
    chk("R8 total symbols", got_n, 72);
    compare("R8 R3 stream");
  endtask

  initial begin
    #(4ns * 200000);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_ones_tail();
    t_gaps();
    t_two_frames();
    t_sof_restart();
    t_four_frames();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule